// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Controller

This controller collects a set of interrupt request flags into ten vectors and presents one vector at a time to a processor core. Each source has its own enable, and several sources can share one vector. Each vector has a two-bit level setting: low, high or top. The top level is available only on the first two vectors. The controller chooses the vector with the highest level. When two candidates have the same level, the one with the lower address wins.

The controller keeps a record of the levels that are currently in service, with at most one entry per level. A request whose level is equal to or lower than the highest level in service is held back. Only a strictly higher level may interrupt a handler that is running. The processor takes the presented vector with an acknowledge strobe and ends a handler with a return strobe. The source flags belong to their peripherals and are cleared by software. The controller never clears them.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset `irqReq` is low, `irqVector` is 0 and no level is in service.
- R2: Sources map to vectors in index order with per-vector counts 1,1,3,3,1,2,1,1,4,4. Sources 0, 1, 2-4, 5-7, 8, 9-10, 11, 12, 13-16 and 17-20 feed vectors 0 to 9 in turn. A vector is pending when any of its sources has both its flag and its enable bit set. A source whose enable is 0 has no effect.
- R3: Bits [2v+1:2v] of `vecLevel` set the level of vector v: 0 is low, 1 is high, 2 or 3 is top. Only vectors 0 and 1 may take the top level. On any other vector, a setting of 2 or 3 acts as high.
- R4: Among the pending vectors that are allowed, the highest level wins. On a tie, the lowest vector index wins.
- R5: The presented address is 0x03 + 8·index, so vector 0 is 0x03 and vector 9 is 0x4B.
- R6: `irqReq` rises one clock after an allowed vector becomes pending. From then until acknowledge, `irqVector` and `irqReq` hold, even if a higher request arrives or the source clears.
- R7: An acknowledge while `irqReq` is high records the presented level as in service, and `irqReq` is low on the next clock. An acknowledge while `irqReq` is low has no effect.
- R8: A pending vector whose level is equal to or lower than the highest level in service is not presented.
- R9: A return removes the highest level in service. A return with nothing in service has no effect. A return in the same cycle as an accepted acknowledge is ignored.
- R10: A strictly higher request interrupts the current service. Nesting reaches low, then high, then top, and each return re-opens the level below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcFlag | input | 21 | Source request flags |
| srcEn | input | 21 | Per-source enables |
| vecLevel | input | 20 | Two-bit level setting per vector |
| intAck | input | 1 | Processor takes the presented vector |
| intRet | input | 1 | Processor ends the current handler |
| irqReq | output | 1 | Interrupt request to the processor |
| irqVector | output | 17 | Address of the presented vector |

## Verification
The bench builds the controller with its default parameters: ten vectors, 21 sources grouped 1,1,3,3,1,2,1,1,4,4, two vectors allowed the top level, and a 17-bit address with base 3 and stride 8. With these values the shared vectors with three and four sources, the clamp of the top setting on vectors above 1, and a full three-deep nest all come within reach. The bench drives each of these directly and also through long random runs of flags, enables, levels and strobes.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  typedef enum logic [1:0] {
    LVL_L = 2'd0,
    LVL_H = 2'd1,
    LVL_X = 2'd2
  } lvl_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch the current winner as the presented vector
  } ivcStrobe_t;

  // a level may be presented only if nothing at or above it is in service
  function automatic logic lvlAllowed(logic [2:0] svc, lvl_e l);
    logic [2:0] above;
    above = svc >> l;
    return above == 3'b000;
  endfunction

  // clear the highest set bit of the in-service mask
  function automatic logic [2:0] popTop(logic [2:0] svc);
    logic [2:0] r;
    r = svc;
    if (svc[2])      r[2] = 1'b0;
    else if (svc[1]) r[1] = 1'b0;
    else             r[0] = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/ivc_datapath.sv
module ivc_datapath
  import ivc_pkg::*;
#(
  parameter int NUM_SRC    = 21,
  parameter int NUM_VEC    = 10,
  parameter int NUM_XVEC   = 2,
  parameter int ADDR_W     = 17,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  parameter logic [4*NUM_VEC-1:0] VEC_SRC_CNT =
    {4'd4, 4'd4, 4'd1, 4'd1, 4'd2, 4'd1, 4'd3, 4'd3, 4'd1, 4'd1}
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   srcFlag,
  input  logic [NUM_SRC-1:0]   srcEn,
  input  logic [2*NUM_VEC-1:0] vecLevel,
  input  logic [2:0]           svcMask,
  input  ivcStrobe_t           strobe,
  output logic                 winValid,
  output lvl_e                 presLvl,
  output logic [ADDR_W-1:0]    irqVector
);

  localparam int IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  function automatic int srcStart(int v);
    int acc;
    acc = 0;
    for (int k = 0; k < v; k++) acc += int'(VEC_SRC_CNT[4*k +: 4]);
    return acc;
  endfunction

  logic [NUM_SRC-1:0] live;
  logic [NUM_VEC-1:0] vecPend;
  logic [NUM_VEC-1:0] vecElig;
  lvl_e               effLvl [NUM_VEC];
  logic [IDX_W-1:0]   winIdx;
  lvl_e               winLvl;

  assign live = srcFlag & srcEn;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    localparam int FIRST = srcStart(v);
    localparam int CNT   = int'(VEC_SRC_CNT[4*v +: 4]);
    logic [1:0] cfg;

    assign cfg        = vecLevel[2*v +: 2];
    assign vecPend[v] = |live[FIRST +: CNT];

    if (v < NUM_XVEC) begin : g_top
      always_comb effLvl[v] = cfg[1] ? LVL_X : lvl_e'(cfg);
    end else begin : g_clamp
      always_comb effLvl[v] = cfg[1] ? LVL_H : lvl_e'(cfg);
    end

    assign vecElig[v] = vecPend[v] && lvlAllowed(svcMask, effLvl[v]);
  end

  // scan from the top index down; ">=" lets the lower index win a tie
  always_comb begin
    winValid = 1'b0;
    winIdx   = '0;
    winLvl   = LVL_L;
    for (int v = NUM_VEC - 1; v >= 0; v--) begin
      if (vecElig[v] && (!winValid || effLvl[v] >= winLvl)) begin
        winValid = 1'b1;
        winIdx   = IDX_W'(v);
        winLvl   = effLvl[v];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      presLvl   <= LVL_L;
      irqVector <= '0;
    end else if (strobe.capture) begin
      presLvl   <= winLvl;
      irqVector <= ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STRIDE) * ADDR_W'(winIdx);
    end
  end

endmodule

// File: rtl/ivc_control.sv
module ivc_control
  import ivc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       intAck,
  input  logic       intRet,
  input  logic       winValid,
  input  lvl_e       presLvl,
  output logic       irqReq,
  output logic [2:0] svcMask,
  output ivcStrobe_t strobe
);

  logic ackTake;
  logic retTake;

  assign ackTake        = intAck && irqReq;
  assign retTake        = intRet && !ackTake;
  assign strobe.capture = !irqReq && winValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqReq  <= 1'b0;
      svcMask <= 3'b000;
    end else if (ackTake) begin
      irqReq  <= 1'b0;
      svcMask <= svcMask | (3'b001 << presLvl);
    end else begin
      if (retTake)        svcMask <= popTop(svcMask);
      if (strobe.capture) irqReq  <= 1'b1;
    end
  end

endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import ivc_pkg::*;
#(
  parameter int NUM_SRC    = 21,
  parameter int NUM_VEC    = 10,
  parameter int NUM_XVEC   = 2,
  parameter int ADDR_W     = 17,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  parameter logic [4*NUM_VEC-1:0] VEC_SRC_CNT =
    {4'd4, 4'd4, 4'd1, 4'd1, 4'd2, 4'd1, 4'd3, 4'd3, 4'd1, 4'd1}
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   srcFlag,
  input  logic [NUM_SRC-1:0]   srcEn,
  input  logic [2*NUM_VEC-1:0] vecLevel,
  input  logic                 intAck,
  input  logic                 intRet,
  output logic                 irqReq,
  output logic [ADDR_W-1:0]    irqVector
);

  logic       winValid;
  lvl_e       presLvl;
  logic [2:0] svcMask;
  ivcStrobe_t strobe;

  ivc_datapath #(
    .NUM_SRC(NUM_SRC), .NUM_VEC(NUM_VEC), .NUM_XVEC(NUM_XVEC),
    .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE),
    .VEC_SRC_CNT(VEC_SRC_CNT)
  ) i_dp (
    .clk(clk), .rstN(rstN), .srcFlag(srcFlag), .srcEn(srcEn),
    .vecLevel(vecLevel), .svcMask(svcMask), .strobe(strobe),
    .winValid(winValid), .presLvl(presLvl), .irqVector(irqVector)
  );

  ivc_control i_ctl (
    .clk(clk), .rstN(rstN), .intAck(intAck), .intRet(intRet),
    .winValid(winValid), .presLvl(presLvl), .irqReq(irqReq),
    .svcMask(svcMask), .strobe(strobe)
  );

endmodule

// File: rtl/ivc_checker.sv
module ivc_checker
  import ivc_pkg::*;
#(
  parameter int NUM_VEC    = 10,
  parameter int NUM_XVEC   = 2,
  parameter int ADDR_W     = 17,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              intAck,
  input logic              intRet,
  input logic              irqReq,
  input logic [ADDR_W-1:0] irqVector,
  input logic [2:0]        svcMask,
  input lvl_e              presLvl
);

  localparam logic [ADDR_W-1:0] TOP_ADDR =
    ADDR_W'(VEC_BASE + VEC_STRIDE * (NUM_VEC - 1));
  localparam logic [ADDR_W-1:0] XLIMIT =
    ADDR_W'(VEC_BASE + VEC_STRIDE * NUM_XVEC);

  a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rstN)
    irqReq && !intAck |=> irqReq && $stable(irqVector));

  a_r7_ack_drops_req: assert property (@(posedge clk) disable iff (!rstN)
    irqReq && intAck |=> !irqReq);

  a_r7_ack_pushes: assert property (@(posedge clk) disable iff (!rstN)
    irqReq && intAck |=> $countones(svcMask) == $past($countones(svcMask)) + 1);

  a_r8_above_ceiling: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> lvlAllowed(svcMask, presLvl));

  a_r9_ret_pops: assert property (@(posedge clk) disable iff (!rstN)
    !(irqReq && intAck) && intRet && svcMask != 3'b000
      |=> $countones(svcMask) == $past($countones(svcMask)) - 1);

  a_r3_top_on_low_vectors: assert property (@(posedge clk) disable iff (!rstN)
    irqReq && presLvl == LVL_X |-> irqVector < XLIMIT);

  a_r5_address_grid: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> ((irqVector - ADDR_W'(VEC_BASE)) % ADDR_W'(VEC_STRIDE)) == '0
               && irqVector <= TOP_ADDR && irqVector >= ADDR_W'(VEC_BASE));

endmodule

bind prio_vec_intc ivc_checker #(
  .NUM_VEC(NUM_VEC), .NUM_XVEC(NUM_XVEC), .ADDR_W(ADDR_W),
  .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
) i_ivcChk (
  .clk(clk), .rstN(rstN), .intAck(intAck), .intRet(intRet),
  .irqReq(irqReq), .irqVector(irqVector), .svcMask(svcMask),
  .presLvl(presLvl)
);

// File: tb/test_prio_vec_intc.sv
`timescale 1ns/1ps
module test_prio_vec_intc;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [20:0] srcFlag = '0;
  logic [20:0] srcEn = '0;
  logic [19:0] vecLevel = '0;
  logic        intAck = 1'b0;
  logic        intRet = 1'b0;
  logic        irqReq;
  logic [16:0] irqVector;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // bench model state
  logic [2:0]  mSvc = 3'b000;
  logic        mIrq = 1'b0;
  logic [1:0]  mLvl = 2'd0;
  logic [16:0] mAddr = '0;

  always #2 clk = ~clk;

  prio_vec_intc i_prio_vec_intc (
    .clk(clk), .rstN(rstN), .srcFlag(srcFlag), .srcEn(srcEn),
    .vecLevel(vecLevel), .intAck(intAck), .intRet(intRet),
    .irqReq(irqReq), .irqVector(irqVector)
  );

  function automatic int vecOfSrc(int s);
    if (s < 1)  return 0;
    if (s < 2)  return 1;
    if (s < 5)  return 2;
    if (s < 8)  return 3;
    if (s < 9)  return 4;
    if (s < 11) return 5;
    if (s < 12) return 6;
    if (s < 13) return 7;
    if (s < 17) return 8;
    return 9;
  endfunction

  function automatic int lvlOf(logic [19:0] lv, int v);
    int c;
    c = int'(lv[2*v +: 2]);
    if (c >= 2) return (v < 2) ? 2 : 1;
    return c;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // advance one clock, update the model from the inputs seen at that edge
  task automatic step();
    bit ackOk, retOk;
    int bv, bl;
    @(posedge clk);
    if (!rstN) begin
      mSvc = 3'b000; mIrq = 1'b0; mLvl = 2'd0; mAddr = '0;
    end else begin
      ackOk = intAck && mIrq;
      retOk = intRet && !ackOk;
      bv = -1; bl = 0;
      for (int v = 0; v < 10; v++) begin
        bit pend;
        int l;
        pend = 1'b0;
        for (int s = 0; s < 21; s++)
          if (vecOfSrc(s) == v && srcFlag[s] && srcEn[s]) pend = 1'b1;
        l = lvlOf(vecLevel, v);
        if (pend && ((mSvc >> l) == 3'b000) && (bv < 0 || l > bl)) begin
          bv = v; bl = l;
        end
      end
      if (ackOk) begin
        mSvc = mSvc | (3'b001 << mLvl);
        mIrq = 1'b0;
      end else begin
        if (retOk) begin
          if (mSvc[2]) mSvc[2] = 1'b0;
          else if (mSvc[1]) mSvc[1] = 1'b0;
          else mSvc[0] = 1'b0;
        end
        if (!mIrq && bv >= 0) begin
          mIrq = 1'b1; mLvl = 2'(bl); mAddr = 17'(3 + 8 * bv);
        end
      end
    end
    @(negedge clk);
    chk("R4 model irqReq", 32'(irqReq), 32'(mIrq));
    chk("R4 model irqVector", 32'(irqVector), 32'(mAddr));
  endtask

  task automatic service();
    intAck = 1'b1; step();
    intAck = 1'b0; srcFlag = '0; intRet = 1'b1; step();
    intRet = 1'b0;
  endtask

  task automatic expectIrq(string tag, logic e, logic [16:0] a);
    chk(tag, 32'(irqReq), 32'(e));
    if (e) chk(tag, 32'(irqVector), 32'(a));
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) step();
    chk("R1 reset irqReq", 32'(irqReq), 0);
    chk("R1 reset irqVector", 32'(irqVector), 0);
    rstN = 1'b1;
    srcEn = '1;

    // R2/R5: shared vector 3 via source 6, all low
    srcFlag = 21'(1) << 6; step();
    expectIrq("R2 shared vector 3", 1'b1, 17'h1B);
    srcFlag = '0; step();
    expectIrq("R6 held after source clears", 1'b1, 17'h1B);
    service();

    // R2: disabled source ignored
    srcEn[16] = 1'b0; srcFlag = 21'(1) << 16; step(); step();
    chk("R2 disabled source", 32'(irqReq), 0);
    srcEn[16] = 1'b1; step();
    expectIrq("R5 vector 8 address", 1'b1, 17'h43);
    service();

    // R4: tie at high, lower index wins
    vecLevel = 20'h55555;
    srcFlag = (21'(1) << 9) | (21'(1) << 12); step();
    expectIrq("R4 tie lowest index", 1'b1, 17'h2B);
    service();
    // R4: higher level beats lower index
    vecLevel = '0; vecLevel[15:14] = 2'd1;
    srcFlag = (21'(1) << 9) | (21'(1) << 12); step();
    expectIrq("R4 level beats index", 1'b1, 17'h3B);
    service();

    // R3: top level on vector 1 beats high on vector 0
    vecLevel = '0; vecLevel[1:0] = 2'd1; vecLevel[3:2] = 2'd2;
    srcFlag = 21'b11; step();
    expectIrq("R3 top on vector 1", 1'b1, 17'h0B);
    service();
    // R3: setting 3 on vector 5 acts as high, ties with vector 2
    vecLevel = '0; vecLevel[11:10] = 2'd3; vecLevel[5:4] = 2'd1;
    srcFlag = (21'(1) << 9) | (21'(1) << 3); step();
    expectIrq("R3 clamp to high", 1'b1, 17'h13);
    service();

    // R8/R10: nesting
    vecLevel = '0; vecLevel[1:0] = 2'd2; vecLevel[5:4] = 2'd1;
    srcFlag = 21'(1) << 11; step();
    expectIrq("R10 low presented", 1'b1, 17'h33);
    intAck = 1'b1; step(); intAck = 1'b0; step();
    chk("R8 same low refused", 32'(irqReq), 0);
    srcFlag = 21'(1) << 12; step();
    chk("R8 other low refused", 32'(irqReq), 0);
    srcFlag = 21'(1) << 3; step();
    expectIrq("R10 high preempts low", 1'b1, 17'h13);
    intAck = 1'b1; step(); intAck = 1'b0; step();
    chk("R8 high refused under high", 32'(irqReq), 0);
    srcFlag = 21'b1; step();
    expectIrq("R10 top preempts high", 1'b1, 17'h03);
    intAck = 1'b1; step(); intAck = 1'b0;
    srcFlag = '0; intRet = 1'b1; step(); intRet = 1'b0;
    srcFlag = (21'(1) << 3) | (21'(1) << 12); step();
    chk("R9 high still in service", 32'(irqReq), 0);
    intRet = 1'b1; step(); intRet = 1'b0; step();
    expectIrq("R9 pop reopens high", 1'b1, 17'h13);
    intAck = 1'b1; step(); intAck = 1'b0;
    srcFlag = 21'(1) << 12; intRet = 1'b1; step(); step(); intRet = 1'b0;
    step();
    expectIrq("R9 pops reopen low", 1'b1, 17'h3B);
    service();

    // R9: return on empty, then ack with simultaneous return
    vecLevel = '0; intRet = 1'b1; step(); intRet = 1'b0;
    srcFlag = 21'(1) << 8; step();
    expectIrq("R9 empty return harmless", 1'b1, 17'h23);
    intAck = 1'b1; intRet = 1'b1; step(); intAck = 1'b0; intRet = 1'b0;
    srcFlag = 21'(1) << 11; step();
    chk("R9 return ignored with ack", 32'(irqReq), 0);
    intRet = 1'b1; step(); intRet = 1'b0; step();
    expectIrq("R9 later return pops", 1'b1, 17'h33);
    service();

    // R7: ack without request has no effect
    srcFlag = '0; intAck = 1'b1; step(); intAck = 1'b0;
    srcFlag = 21'(1) << 8; step();
    expectIrq("R7 stray ack ignored", 1'b1, 17'h23);
    service();

    // R6: held while a higher request arrives, then top preempts
    vecLevel = '0; vecLevel[1:0] = 2'd2;
    srcFlag = 21'(1) << 17; step();
    expectIrq("R6 vector 9", 1'b1, 17'h4B);
    srcFlag = srcFlag | 21'b1; step();
    expectIrq("R6 held against top", 1'b1, 17'h4B);
    intAck = 1'b1; step(); intAck = 1'b0;
    chk("R7 ack drops request", 32'(irqReq), 0);
    step();
    expectIrq("R10 top after ack", 1'b1, 17'h03);
    service();
    intRet = 1'b1; step(); intRet = 1'b0;

    // random phase, checked against the model every cycle
    for (int n = 0; n < 4000; n++) begin
      if (n % 60 == 0) vecLevel = 20'($urandom);
      if (n % 5 == 0) begin
        logic [20:0] a, b, c;
        a = 21'($urandom); b = 21'($urandom); c = 21'($urandom);
        srcFlag = a & b & c;
        srcEn = ~(21'($urandom) & 21'($urandom));
      end
      intAck = (irqReq && ($urandom % 3 == 0)) || ($urandom % 17 == 0);
      intRet = ($urandom % 6 == 0);
      step();
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule